// File: doc/BRIEF.md
# Sensor Register Bank with Graded Wake Sequencer

This block is the register-side front end of a digital magnetic sensor. It holds the latest magnetic-field sample and the latest die-temperature sample, each 12 bits in two's complement, plus a sleep control bit. All of them are reached over a simple register bus with address, write data, write strobe, read strobe and registered read data. Samples come from the sensing path on input ports, each with its own valid strobe, in a separate system clock domain.

The sleep bit is held in the bus clock domain. Setting it raises a power-down output at once and holds the system-side wake sequencer in reset. Clearing it works even when the system clock is stopped. Once the system clock runs, a counter steps a readiness stage through three timed levels. The first level is bus responsive. The second gives valid output that is not temperature compensated. The third gives output at full accuracy. The three delays are microsecond parameters scaled by a clock-frequency parameter. The current stage can be read back from a status register.

The field value is a signed count where zero means no applied field. The temperature value is a signed count where zero means 25 °C, at roughly 8 counts per degree. All values and the stage cross between the two clock domains through toggle-handshake word transfers.

Top module: `snsr_bank`

## Requirements
- R1: A read of address 0x1F returns the last accepted field sample in bits [11:0], with the upper read-data bits zero, once the stage is nonzero.
- R2: A read of address 0x1D returns the last accepted temperature sample in bits [11:0], with the upper bits zero, once the stage is nonzero.
- R3: Bit 0 of address 0x20 is the sleep bit. It is read/write, resets to 1 (asleep) and reads back as written.
- R4: `pd_o` equals the sleep bit. It changes on the bus clock edge that takes the write and does not depend on the system clock.
- R5: Address 0x21 bits [1:0] report the stage: 0 asleep or waking, 1 bus ready, 2 uncompensated, 3 accurate. While awake the stage never decreases, and it passes through 1, 2 and 3 in that order.
- R6: While the reported stage is 0, reads of 0x1D and 0x1F return zero. Addresses 0x20 and 0x21 keep responding.
- R7: Sample valid strobes are ignored unless the system-side stage is 2 or 3. The held sample values survive sleep.
- R8: Writing sleep = 1 during any wake stage forces the reported stage to 0 and raises `pd_o` on that bus edge. A later clear restarts all delays from zero.
- R9: Writes to 0x1D, 0x1F and 0x21 change nothing. Reads of any unmapped address return zero.
- R10: The sleep bit can be cleared while the system clock is stopped. The wake sequence starts when the system clock resumes.
- R11: Stage k is entered after US_k × CLK_MHZ system cycles (50, 150 and 500 µs by default). With equal clocks it is visible on the bus between that count and 12 bus cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Register bus clock; also clocks the sleep bit |
| sys_clk_i | input | 1 | System clock for sequencer and sample capture; may stop |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Read data, valid the cycle after `rd_i`, zero otherwise |
| field_i | input | SAMPLE_W | Field sample from the sensing path |
| field_vld_i | input | 1 | Field sample strobe |
| temp_i | input | SAMPLE_W | Temperature sample |
| temp_vld_i | input | 1 | Temperature sample strobe |
| pd_o | output | 1 | Power-down to controlled subsystems |

## Verification
The bench times every stage transition against its programmed delay. A sequencer counting from the wrong point, or skipping a stage, would show up as a transition outside its window. It aborts in stage 2 with a one-cycle sleep pulse. A design that only sampled the sleep level in the system domain would miss that pulse and report a stale stage, or would resume without restarting the delays. It clears sleep with the system clock stopped, so a sleep bit held in the wrong domain would leave `pd_o` stuck high. Sample strobes are sent in stage 1 and while asleep. Random samples, read-only writes and unmapped reads in stage 3 catch capture gating or decode that overwrites held values or leaks data.

// File: rtl/snsr_pkg.sv
package snsr_pkg;
  localparam logic [7:0] ADDR_TEMP  = 8'h1D;
  localparam logic [7:0] ADDR_FIELD = 8'h1F;
  localparam logic [7:0] ADDR_CTRL  = 8'h20;
  localparam logic [7:0] ADDR_STAT  = 8'h21;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_BUS = 2'd1,
    ST_RAW = 2'd2,
    ST_ACC = 2'd3
  } stage_e;
endpackage

// File: rtl/snsr_xfer.sv
// Toggle-handshake word transfer; newest value wins while a transfer is in flight.
module snsr_xfer #(
  parameter int unsigned W = 8
) (
  input  logic         src_clk_i,
  input  logic         src_rst_ni,
  input  logic [W-1:0] src_d_i,
  input  logic         src_upd_i,
  input  logic         dst_clk_i,
  input  logic         dst_rst_ni,
  output logic [W-1:0] dst_q_o,
  output logic         dst_new_o
);
  logic [W-1:0] hold_q;
  logic         req_q, pend_q, ack_q, busy;
  logic [1:0]   ack_sync_q, req_sync_q;

  assign busy = req_q ^ ack_sync_q[1];

  always_ff @(posedge src_clk_i or negedge src_rst_ni) begin
    if (!src_rst_ni) begin
      hold_q     <= '0;
      req_q      <= 1'b0;
      pend_q     <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[0], ack_q};
      if (!busy && (pend_q || src_upd_i)) begin
        hold_q <= src_d_i;
        req_q  <= ~req_q;
        pend_q <= 1'b0;
      end else if (src_upd_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge dst_clk_i or negedge dst_rst_ni) begin
    if (!dst_rst_ni) begin
      req_sync_q <= '0;
      ack_q      <= 1'b0;
      dst_q_o    <= '0;
      dst_new_o  <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[0], req_q};
      dst_new_o  <= 1'b0;
      if (req_sync_q[1] != ack_q) begin
        dst_q_o   <= hold_q;  // stable: src holds it until ack returns
        ack_q     <= req_sync_q[1];
        dst_new_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/snsr_wake_seq.sv
module snsr_wake_seq
  import snsr_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned BUS_US  = 50,
  parameter int unsigned RAW_US  = 150,
  parameter int unsigned ACC_US  = 500
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sleep_i,
  output stage_e stage_o,
  output logic   stage_upd_o
);
  localparam int unsigned D_BUS = BUS_US * CLK_MHZ;
  localparam int unsigned D_RAW = RAW_US * CLK_MHZ;
  localparam int unsigned D_ACC = ACC_US * CLK_MHZ;
  localparam int unsigned CW    = $clog2(D_ACC + 1);

  logic          arst_n, srst_n;
  logic [1:0]    rsync_q;
  logic [CW-1:0] cnt_q;
  stage_e        stage_d, stage_q;
  logic [2:0]    prev_q;

  // sleep asserts the sequencer reset asynchronously; release is synchronized
  assign arst_n = rst_ni & ~sleep_i;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n)                 cnt_q <= '0;
    else if (cnt_q != CW'(D_ACC)) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if      (cnt_q >= CW'(D_ACC)) stage_d = ST_ACC;
    else if (cnt_q >= CW'(D_RAW)) stage_d = ST_RAW;
    else if (cnt_q >= CW'(D_BUS)) stage_d = ST_BUS;
    else                          stage_d = ST_OFF;
  end

  // prev resets to an impossible code so every sleep reset republishes stage 0
  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      stage_q <= ST_OFF;
      prev_q  <= 3'b100;
    end else begin
      stage_q <= stage_d;
      prev_q  <= {1'b0, stage_q};
    end
  end

  assign stage_o     = stage_q;
  assign stage_upd_o = ({1'b0, stage_q} != prev_q);
endmodule

// File: rtl/snsr_capture.sv
module snsr_capture
  import snsr_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  stage_e                stage_i,
  input  logic [SAMPLE_W-1:0]   field_i,
  input  logic                  field_vld_i,
  input  logic [SAMPLE_W-1:0]   temp_i,
  input  logic                  temp_vld_i,
  output logic [2*SAMPLE_W-1:0] data_o,
  output logic                  upd_o
);
  logic                accept;
  logic [SAMPLE_W-1:0] field_q, temp_q;

  assign accept = (stage_i == ST_RAW) || (stage_i == ST_ACC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      temp_q  <= '0;
      upd_o   <= 1'b0;
    end else begin
      if (accept && field_vld_i) field_q <= field_i;
      if (accept && temp_vld_i)  temp_q  <= temp_i;
      upd_o <= accept && (field_vld_i || temp_vld_i);
    end
  end

  assign data_o = {temp_q, field_q};
endmodule

// File: rtl/snsr_regs.sv
module snsr_regs
  import snsr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [2*SAMPLE_W-1:0] smp_i,
  input  logic [1:0]            stage_i,
  input  logic                  stage_new_i,
  output logic                  sleep_o,
  output stage_e                status_o
);
  logic              sleep_q, need_zero_q, wr_ctrl, set_sleep;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];
  assign wr_ctrl      = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign set_sleep    = wr_ctrl && wdata_i[0] && !sleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q     <= 1'b1;
      need_zero_q <= 1'b0;
    end else begin
      if (wr_ctrl) sleep_q <= wdata_i[0];
      // mask stale in-flight stages until the sequencer reports its reset
      if (set_sleep)                                  need_zero_q <= 1'b1;
      else if (stage_new_i && stage_i == 2'(ST_OFF)) need_zero_q <= 1'b0;
    end
  end

  assign status_o = (sleep_q || need_zero_q) ? ST_OFF : stage_e'(stage_i);
  assign sleep_o  = sleep_q;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(ADDR_TEMP):  if (status_o != ST_OFF) rd_mux = DATA_W'(smp_i[2*SAMPLE_W-1:SAMPLE_W]);
      ADDR_W'(ADDR_FIELD): if (status_o != ST_OFF) rd_mux = DATA_W'(smp_i[SAMPLE_W-1:0]);
      ADDR_W'(ADDR_CTRL):  rd_mux = DATA_W'(sleep_q);
      ADDR_W'(ADDR_STAT):  rd_mux = DATA_W'(status_o);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/snsr_bank.sv
module snsr_bank
  import snsr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned CLK_MHZ  = 50,
  parameter int unsigned BUS_US   = 50,
  parameter int unsigned RAW_US   = 150,
  parameter int unsigned ACC_US   = 500
) (
  input  logic                bus_clk_i,
  input  logic                sys_clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [SAMPLE_W-1:0] field_i,
  input  logic                field_vld_i,
  input  logic [SAMPLE_W-1:0] temp_i,
  input  logic                temp_vld_i,
  output logic                pd_o
);
  localparam int unsigned SMP_W = 2 * SAMPLE_W;

  logic             sleep_w, stage_upd_w, smp_upd_w, stage_new_w, smp_new_w;
  stage_e           stage_sys_w, status_w;
  logic [1:0]       stage_bus_w;
  logic [SMP_W-1:0] smp_sys_w, smp_bus_w;
  logic             unused_smp_new;

  assign unused_smp_new = smp_new_w;

  snsr_wake_seq #(
    .CLK_MHZ(CLK_MHZ), .BUS_US(BUS_US), .RAW_US(RAW_US), .ACC_US(ACC_US)
  ) u_seq (
    .clk_i      (sys_clk_i),
    .rst_ni     (rst_ni),
    .sleep_i    (sleep_w),
    .stage_o    (stage_sys_w),
    .stage_upd_o(stage_upd_w)
  );

  snsr_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk_i      (sys_clk_i),
    .rst_ni     (rst_ni),
    .stage_i    (stage_sys_w),
    .field_i    (field_i),
    .field_vld_i(field_vld_i),
    .temp_i     (temp_i),
    .temp_vld_i (temp_vld_i),
    .data_o     (smp_sys_w),
    .upd_o      (smp_upd_w)
  );

  snsr_xfer #(.W(2)) u_stage_x (
    .src_clk_i (sys_clk_i),
    .src_rst_ni(rst_ni),
    .src_d_i   (stage_sys_w),
    .src_upd_i (stage_upd_w),
    .dst_clk_i (bus_clk_i),
    .dst_rst_ni(rst_ni),
    .dst_q_o   (stage_bus_w),
    .dst_new_o (stage_new_w)
  );

  snsr_xfer #(.W(SMP_W)) u_smp_x (
    .src_clk_i (sys_clk_i),
    .src_rst_ni(rst_ni),
    .src_d_i   (smp_sys_w),
    .src_upd_i (smp_upd_w),
    .dst_clk_i (bus_clk_i),
    .dst_rst_ni(rst_ni),
    .dst_q_o   (smp_bus_w),
    .dst_new_o (smp_new_w)
  );

  snsr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)) u_regs (
    .clk_i      (bus_clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .rdata_o    (rdata_o),
    .smp_i      (smp_bus_w),
    .stage_i    (stage_bus_w),
    .stage_new_i(stage_new_w),
    .sleep_o    (sleep_w),
    .status_o   (status_w)
  );

  assign pd_o = sleep_w;
endmodule

// File: rtl/snsr_bank_chk.sv
module snsr_bank_chk
  import snsr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SAMPLE_W = 12
) (
  input logic                  bus_clk_i,
  input logic                  sys_clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic                  pd_o,
  input stage_e                status,
  input stage_e                stage_sys,
  input logic [2*SAMPLE_W-1:0] smp_sys
);
  logic mapped, smp_addr;
  assign smp_addr = (addr_i == ADDR_W'(ADDR_TEMP)) || (addr_i == ADDR_W'(ADDR_FIELD));
  assign mapped   = smp_addr || (addr_i == ADDR_W'(ADDR_CTRL)) || (addr_i == ADDR_W'(ADDR_STAT));

  p_pd_follows_sleep_r4: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(ADDR_CTRL)) |=> (pd_o == $past(wdata_i[0])));

  p_asleep_stage_off_r8: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    pd_o |-> (status == ST_OFF));

  p_stage_no_regress_r5: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (!pd_o && $past(!pd_o)) |-> (status >= $past(status)));

  p_unmapped_zero_r9: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |=> (rdata_o == '0));

  p_gated_read_r6: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (rd_i && smp_addr && status == ST_OFF) |=> (rdata_o == '0));

  p_hold_early_r7: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (stage_sys == ST_OFF || stage_sys == ST_BUS) |=> $stable(smp_sys));
endmodule

bind snsr_bank snsr_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .bus_clk_i(bus_clk_i),
  .sys_clk_i(sys_clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .pd_o     (pd_o),
  .status   (status_w),
  .stage_sys(stage_sys_w),
  .smp_sys  (smp_sys_w)
);

// File: tb/tb_snsr_bank.sv
module tb_snsr_bank;
  import snsr_pkg::*;

  localparam int D1 = 50, D2 = 150, D3 = 500, SLK = 12;

  logic        bus_clk = 1'b0, sys_clk = 1'b0, sys_run = 1'b1, rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        wr = 1'b0, rd = 1'b0, pd;
  logic [11:0] field = '0, temp = '0;
  logic        fvld = 1'b0, tvld = 1'b0;
  int          checks = 0, fails = 0;
  longint      cyc = 0;
  bit          done = 1'b0;
  logic [11:0] f_m = '0, t_m = '0;

  snsr_bank #(.CLK_MHZ(1)) dut (
    .bus_clk_i(bus_clk), .sys_clk_i(sys_clk), .rst_ni(rst_ni),
    .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .field_i(field), .field_vld_i(fvld), .temp_i(temp), .temp_vld_i(tvld),
    .pd_o(pd)
  );

  always #10 bus_clk = ~bus_clk;
  initial begin
    #5;
    forever begin
      #10;
      if (sys_run) sys_clk = ~sys_clk;
      else         sys_clk = 1'b0;
    end
  end
  always @(posedge bus_clk) cyc++;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge bus_clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    @(negedge bus_clk);
    d = rdata; rd = 1'b0;
  endtask

  task automatic push(logic [11:0] f, bit fv, logic [11:0] t, bit tv, bit acc);
    field = f; temp = t; fvld = fv; tvld = tv;
    @(negedge bus_clk);
    fvld = 1'b0; tvld = 1'b0;
    if (acc && fv) f_m = f;
    if (acc && tv) t_m = t;
    repeat (12) @(negedge bus_clk);
  endtask

  task automatic wait_stage(int k, longint t0, string req);
    logic [15:0] v;
    int dk;
    dk = (k == 1) ? D1 : (k == 2) ? D2 : D3;
    forever begin
      rd_reg(ADDR_STAT, v);
      if (v[1:0] == 2'(k)) begin
        chk((cyc - t0) >= dk && (cyc - t0) <= dk + SLK, req, cyc - t0, dk);
        return;
      end
      if (v > 16'(k) || (cyc - t0) > dk + SLK) begin
        chk(1'b0, req, v, k);
        return;
      end
    end
  endtask

  function automatic bit is_mapped(logic [7:0] a);
    return a == ADDR_TEMP || a == ADDR_FIELD || a == ADDR_CTRL || a == ADDR_STAT;
  endfunction

  initial begin
    logic [15:0] v;
    longint t0;
    logic [7:0] ra;
    logic [11:0] rf, rt;
    void'($urandom(32'h51ee_0d17));
    repeat (4) @(negedge bus_clk);
    rst_ni = 1'b1;
    @(negedge bus_clk);

    // reset state
    chk(pd == 1'b1, "R4 pd after reset", pd, 1);
    rd_reg(ADDR_CTRL, v);  chk(v == 16'h1, "R3 sleep reset value", v, 1);
    rd_reg(ADDR_STAT, v);  chk(v == 16'h0, "R5 stage after reset", v, 0);
    wr_reg(ADDR_FIELD, 16'h0555);
    rd_reg(ADDR_CTRL, v);  chk(v == 16'h1, "R6 ctrl responds while asleep", v, 1);

    // first wake
    wr_reg(ADDR_CTRL, 16'h0); t0 = cyc;
    chk(pd == 1'b0, "R4 pd clears on write", pd, 0);
    rd_reg(ADDR_CTRL, v);  chk(v == 16'h0, "R3 sleep reads back 0", v, 0);
    wait_stage(1, t0, "R11 R5 bus stage timing");
    push(12'hABC, 1'b1, 12'h111, 1'b1, 1'b0);
    rd_reg(ADDR_FIELD, v); chk(v == 16'h0, "R7 field strobe ignored in stage 1", v, 0);
    rd_reg(ADDR_TEMP, v);  chk(v == 16'h0, "R7 temp strobe ignored in stage 1", v, 0);
    wait_stage(2, t0, "R11 R5 raw stage timing");
    push(12'h123, 1'b1, 12'hF38, 1'b1, 1'b1);
    rd_reg(ADDR_FIELD, v); chk(v == {4'h0, f_m}, "R1 field in stage 2", v, f_m);
    rd_reg(ADDR_TEMP, v);  chk(v == {4'h0, t_m}, "R2 temp in stage 2", v, t_m);
    wait_stage(3, t0, "R11 R5 accurate stage timing");

    // random traffic in stage 3
    for (int i = 0; i < 40; i++) begin
      rf = 12'($urandom()); rt = 12'($urandom());
      push(rf, 1'($urandom()), rt, 1'($urandom()), 1'b1);
      rd_reg(ADDR_FIELD, v); chk(v == {4'h0, f_m}, "R1 random field", v, f_m);
      rd_reg(ADDR_TEMP, v);  chk(v == {4'h0, t_m}, "R2 random temp", v, t_m);
      do ra = 8'($urandom()); while (is_mapped(ra));
      rd_reg(ra, v); chk(v == 16'h0, "R9 unmapped read", v, 0);
      case ($urandom() % 3)
        0:       ra = ADDR_TEMP;
        1:       ra = ADDR_FIELD;
        default: ra = ADDR_STAT;
      endcase
      wr_reg(ra, 16'($urandom()));
      rd_reg(ADDR_FIELD, v); chk(v == {4'h0, f_m}, "R9 ro write field", v, f_m);
      rd_reg(ADDR_TEMP, v);  chk(v == {4'h0, t_m}, "R9 ro write temp", v, t_m);
      rd_reg(ADDR_STAT, v);  chk(v == 16'h3, "R9 ro write status", v, 3);
    end

    // sleep: held values, ignored strobes, gated reads
    wr_reg(ADDR_CTRL, 16'h1);
    chk(pd == 1'b1, "R4 pd sets on write", pd, 1);
    rd_reg(ADDR_STAT, v);  chk(v == 16'h0, "R8 stage 0 on sleep", v, 0);
    push(12'h7FF, 1'b1, 12'h7FF, 1'b1, 1'b0);
    rd_reg(ADDR_FIELD, v); chk(v == 16'h0, "R6 field gated asleep", v, 0);
    wr_reg(ADDR_CTRL, 16'h0); t0 = cyc;
    wait_stage(1, t0, "R11 rewake bus stage");
    rd_reg(ADDR_FIELD, v); chk(v == {4'h0, f_m}, "R7 field held across sleep", v, f_m);
    rd_reg(ADDR_TEMP, v);  chk(v == {4'h0, t_m}, "R7 temp held across sleep", v, t_m);
    wait_stage(2, t0, "R5 rewake raw stage");

    // abort in stage 2 with a one-cycle sleep pulse
    wr_reg(ADDR_CTRL, 16'h1);
    chk(pd == 1'b1, "R8 abort pd", pd, 1);
    wr_reg(ADDR_CTRL, 16'h0); t0 = cyc;
    rd_reg(ADDR_STAT, v);  chk(v == 16'h0, "R8 abort stage 0", v, 0);
    wait_stage(1, t0, "R8 delays restart after abort");

    // wake with system clock stopped
    wr_reg(ADDR_CTRL, 16'h1);
    repeat (4) @(negedge bus_clk);
    sys_run = 1'b0;
    repeat (4) @(negedge bus_clk);
    wr_reg(ADDR_CTRL, 16'h0);
    chk(pd == 1'b0, "R10 pd clears with sys clock stopped", pd, 0);
    repeat (200) @(negedge bus_clk);
    rd_reg(ADDR_STAT, v);  chk(v == 16'h0, "R10 no progress while stopped", v, 0);
    rd_reg(ADDR_CTRL, v);  chk(v == 16'h0, "R10 sleep stays clear", v, 0);
    sys_run = 1'b1; t0 = cyc;
    wait_stage(1, t0, "R10 wake after clock resumes");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule